// File: doc/BRIEF.md
# Pseudo-Noise Burst Serializer

This block produces a pseudo-random binary reference signal that several receivers can pick up and cross-correlate in order to measure their relative delay. A 31-stage maximal-length shift register with linear feedback generates the sequence. Each time a new byte is needed, the register advances eight steps in one cycle. The byte is then shifted out on a serial data line, first-generated bit first. A serial clock is produced alongside it, and its bit period is derived from a 16 MHz system clock by a programmable divider.

Three modes are available:

- **Continuous:** the sequence streams without a break.
- **Short burst:** 64-bit blocks are sent, each followed by an idle gap of pseudo-random length.
- **Long burst:** multi-thousand-bit blocks are sent, separated by much longer pseudo-random gaps.

A run-enable input starts and stops the stream, but only at clean byte or gap boundaries. The busy flag is high while bits are being emitted.

Top module: `pnBurstSerializer`

## Requirements
- R1: The generator is a 31-stage Fibonacci register `s[30:0]`, loaded with SEED (default 1) on reset. Each step outputs `s[30]` and shifts in `s[30]^s[27]` at `s[0]` (taps at stages 31 and 28). The serial bit stream is the uninterrupted run of these outputs, across byte boundaries, gaps and idle periods. The register advances only when a byte is produced.
- R2: Bits leave in groups of eight. Within a byte, the first-generated bit is sent first, in the MSB position.
- R3: The bit period is `8 << rateSel` system clocks for rateSel 0 to 4, which gives 2, 1, 0.5, 0.25 and 0.125 Mbps at 16 MHz. The codes 5 to 7 act as code 4.
- R4: A new rateSel value is taken up only when the next byte is loaded. A byte already in flight keeps its old period.
- R5: In short-burst mode (mode = 01), 64 bits are sent and then a gap of G bit periods follows, where G = 16 + (low 6 bits of the generator state after the burst's last byte). busy is low during the gap.
- R6: serClk is low for the first half of each bit period and high for the second half. serData changes only as serClk falls. Both lines are low whenever busy is low.
- R7: In long-burst mode (mode = 1x), LONG_BYTES*8 bits are sent (default 6000). The gap that follows is LGAP_MIN + (low LGAP_W bits of the state), with defaults 4096 and 12.
- R8: In continuous mode (mode = 00), bits follow each other with no gap.
- R9: While idle, a high enable starts a run. A low enable stops the stream at the next byte boundary, or at the end of a gap. Raising enable again resumes the same sequence.
- R10: During reset and afterwards, with enable low, serClk, serData and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (16 MHz nominal) |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable |
| mode | input | 2 | 00 continuous, 01 short burst, 1x long burst |
| rateSel | input | RATE_W | Bit-rate code, divider 8 << code |
| serData | output | 1 | Serial pseudo-noise data |
| serClk | output | 1 | Serial clock, rising edge mid-bit |
| busy | output | 1 | High while bits are being emitted |

## Verification
The bench keeps the default generator seed, divider base and short-burst settings. It overrides LONG_BYTES to 6, LGAP_MIN to 40 and LGAP_W to 4, so a complete long burst and its gap finish within a few hundred cycles. That shortening lets one run cover the gap arithmetic of both burst modes, the byte-boundary take-up of a rate change, the clamping of out-of-range rate codes, and a stop and resume that must continue the sequence.

// File: rtl/pnPkg.sv
package pnPkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_GAP} pnState_e;

  typedef struct packed {
    logic load;     // advance generator one byte, load shifter
    logic shift;    // move to next bit of the byte
    logic gapLoad;  // start a gap count
    logic gapDec;   // one gap slot elapsed
    logic longGap;  // gap length uses long-mode constants
  } pnStrobe_t;
endpackage

// File: rtl/pnDatapath.sv
module pnDatapath import pnPkg::*; #(
  parameter int LFSR_LEN = 31,
  parameter int TAP_B    = 28,
  parameter logic [LFSR_LEN-1:0] SEED = 1,
  parameter int BYTE_W   = 8,
  parameter int GAP_MIN  = 16,
  parameter int GAP_W    = 6,
  parameter int LGAP_MIN = 4096,
  parameter int LGAP_W   = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  pnStrobe_t  stb,
  output logic       dataBit,
  output logic       gapLast
);
  localparam int GMAX_S = GAP_MIN + (1 << GAP_W);
  localparam int GMAX_L = LGAP_MIN + (1 << LGAP_W);
  localparam int GC_W   = $clog2(((GMAX_S > GMAX_L) ? GMAX_S : GMAX_L) + 1);

  logic [LFSR_LEN-1:0] lfsrQ, lfsrNxt;
  logic [BYTE_W-1:0]   shQ, byteNew;
  logic [GC_W-1:0]     gapQ, gapLen;

  // Eight feedback steps unrolled into one cycle
  always_comb begin
    lfsrNxt = lfsrQ;
    byteNew = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      byteNew[BYTE_W-1-i] = lfsrNxt[LFSR_LEN-1];
      lfsrNxt = {lfsrNxt[LFSR_LEN-2:0], lfsrNxt[LFSR_LEN-1] ^ lfsrNxt[TAP_B-1]};
    end
    if (lfsrNxt == '0) lfsrNxt = SEED;
  end

  always_comb begin
    if (stb.longGap) gapLen = GC_W'(LGAP_MIN) + GC_W'(lfsrQ[LGAP_W-1:0]);
    else             gapLen = GC_W'(GAP_MIN)  + GC_W'(lfsrQ[GAP_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ <= SEED;
      shQ   <= '0;
      gapQ  <= '0;
    end else begin
      if (stb.load) begin
        lfsrQ <= lfsrNxt;
        shQ   <= byteNew;
      end else if (stb.shift) begin
        shQ <= {shQ[BYTE_W-2:0], 1'b0};
      end
      if (stb.gapLoad)     gapQ <= gapLen;
      else if (stb.gapDec) gapQ <= gapQ - 1'b1;
    end
  end

  assign dataBit = shQ[BYTE_W-1];
  assign gapLast = (gapQ == GC_W'(1));
endmodule

// File: rtl/pnControl.sv
module pnControl import pnPkg::*; #(
  parameter int BYTE_W      = 8,
  parameter int RATE_W      = 3,
  parameter int MAX_RATE    = 4,
  parameter int BASE_DIV    = 8,
  parameter int BURST_BYTES = 8,
  parameter int LONG_BYTES  = 750
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              gapLast,
  output pnStrobe_t         stb,
  output logic              serClk,
  output logic              busy
);
  localparam int MAX_DIV = BASE_DIV << MAX_RATE;
  localparam int CNT_W   = $clog2(MAX_DIV);
  localparam int BIT_W   = $clog2(BYTE_W);
  localparam int MAXB    = (LONG_BYTES > BURST_BYTES) ? LONG_BYTES : BURST_BYTES;
  localparam int BC_W    = $clog2(MAXB + 1);

  pnState_e          stQ, stD;
  logic [CNT_W-1:0]  cntQ, divM1, halfDiv;
  logic [RATE_W-1:0] rateQ, rateNew;
  logic [BIT_W-1:0]  bitQ;
  logic [BC_W-1:0]   byteQ, lastQ;
  logic              contQ, longQ;
  logic              slotEnd, startBurst, nextByte;

  always_comb begin
    rateNew = (rateSel > RATE_W'(MAX_RATE)) ? RATE_W'(MAX_RATE) : rateSel;
    divM1   = CNT_W'((BASE_DIV << rateQ) - 1);
    halfDiv = CNT_W'((BASE_DIV / 2) << rateQ);
    slotEnd = (stQ != ST_IDLE) && (cntQ == divM1);
  end

  always_comb begin
    stb        = '0;
    stD        = stQ;
    startBurst = 1'b0;
    nextByte   = 1'b0;
    case (stQ)
      ST_IDLE: if (enable) begin
        startBurst = 1'b1;
        stD        = ST_SEND;
      end
      ST_SEND: if (slotEnd) begin
        if (bitQ != BIT_W'(BYTE_W - 1)) stb.shift = 1'b1;
        else if (!contQ && byteQ == lastQ) begin
          stb.gapLoad = 1'b1;
          stb.longGap = longQ;
          stD         = ST_GAP;
        end
        else if (!enable) stD = ST_IDLE;
        else nextByte = 1'b1;
      end
      ST_GAP: if (slotEnd) begin
        if (!gapLast) stb.gapDec = 1'b1;
        else if (enable) begin
          startBurst = 1'b1;
          stD        = ST_SEND;
        end
        else stD = ST_IDLE;
      end
      default: stD = ST_IDLE;
    endcase
    stb.load = startBurst | nextByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      cntQ  <= '0;
      rateQ <= '0;
      bitQ  <= '0;
      byteQ <= '0;
      lastQ <= '0;
      contQ <= 1'b1;
      longQ <= 1'b0;
    end else begin
      stQ <= stD;
      if (stb.load || slotEnd || stD == ST_IDLE) cntQ <= '0;
      else                                       cntQ <= cntQ + 1'b1;
      if (stb.load) begin
        rateQ <= rateNew;
        bitQ  <= '0;
      end else if (stb.shift) begin
        bitQ <= bitQ + 1'b1;
      end
      if (startBurst) begin
        byteQ <= '0;
        contQ <= (mode == 2'b00);
        longQ <= mode[1];
        lastQ <= mode[1] ? BC_W'(LONG_BYTES - 1) : BC_W'(BURST_BYTES - 1);
      end else if (nextByte) begin
        byteQ <= byteQ + 1'b1;
      end
    end
  end

  assign serClk = (stQ == ST_SEND) && (cntQ >= halfDiv);
  assign busy   = (stQ == ST_SEND);
endmodule

// File: rtl/pnBurstSerializer.sv
module pnBurstSerializer import pnPkg::*; #(
  parameter int LFSR_LEN    = 31,
  parameter int TAP_B       = 28,
  parameter logic [LFSR_LEN-1:0] SEED = 1,
  parameter int BYTE_W      = 8,
  parameter int RATE_W      = 3,
  parameter int MAX_RATE    = 4,
  parameter int BASE_DIV    = 8,
  parameter int BURST_BYTES = 8,
  parameter int GAP_MIN     = 16,
  parameter int GAP_W       = 6,
  parameter int LONG_BYTES  = 750,
  parameter int LGAP_MIN    = 4096,
  parameter int LGAP_W      = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic [RATE_W-1:0] rateSel,
  output logic              serData,
  output logic              serClk,
  output logic              busy
);
  pnStrobe_t stb;
  logic      dataBit, gapLast;

  pnControl #(
    .BYTE_W(BYTE_W), .RATE_W(RATE_W), .MAX_RATE(MAX_RATE), .BASE_DIV(BASE_DIV),
    .BURST_BYTES(BURST_BYTES), .LONG_BYTES(LONG_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode), .rateSel(rateSel),
    .gapLast(gapLast), .stb(stb), .serClk(serClk), .busy(busy)
  );

  pnDatapath #(
    .LFSR_LEN(LFSR_LEN), .TAP_B(TAP_B), .SEED(SEED), .BYTE_W(BYTE_W),
    .GAP_MIN(GAP_MIN), .GAP_W(GAP_W), .LGAP_MIN(LGAP_MIN), .LGAP_W(LGAP_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .dataBit(dataBit), .gapLast(gapLast)
  );

  assign serData = busy & dataBit;
endmodule

// File: rtl/pnBurstSerializer_chk.sv
module pnBurstSerializer_chk (
  input logic clk,
  input logic rstN,
  input logic serData,
  input logic serClk,
  input logic busy
);
  // R6: data held while the serial clock is high
  assert_data_stable_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (serClk && $past(serClk)) |-> $stable(serData));

  // R6: both lines quiet when nothing is being emitted
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!serClk && !serData));

  // R9: emission stops only at the end of a full bit slot
  assert_stop_on_slot_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(serClk));

  // R6: every run begins with the low half of a slot
  assert_start_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> !serClk);

  // R3: high half lasts more than one system clock
  assert_clk_high_min_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serClk) |=> serClk);
endmodule

bind pnBurstSerializer pnBurstSerializer_chk u_chk (
  .clk(clk), .rstN(rstN), .serData(serData), .serClk(serClk), .busy(busy)
);

// File: tb/pnBurstSerializer_tb.sv
`timescale 1ns/100ps
module pnBurstSerializer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [2:0] rateSel = 3'd0;
  logic serData, serClk, busy;

  int checks = 0;
  int errors = 0;
  int stabFails = 0;
  int cyc = 0;
  int nRise = 0;
  int lastRise = 0;
  bit prevClk = 1'b0;
  bit prevData = 1'b0;
  bit bitBuf [0:4095];
  int ivBuf [0:4095];
  bit expSeq [0:1023];
  logic [30:0] stateAt [0:127];

  always #2.5 clk = ~clk;

  pnBurstSerializer #(.LONG_BYTES(6), .LGAP_MIN(40), .LGAP_W(4)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode), .rateSel(rateSel),
    .serData(serData), .serClk(serClk), .busy(busy)
  );

  // Receiver model: capture data on each serial clock rise
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (serClk && !prevClk) begin
      bitBuf[nRise % 4096] <= serData;
      ivBuf[nRise % 4096]  <= cyc - lastRise;
      lastRise <= cyc;
      nRise <= nRise + 1;
    end
    if (rstN && serClk && prevClk && serData != prevData) stabFails <= stabFails + 1;
    prevClk  <= serClk;
    prevData <= serData;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitRises(input int n);
    while (nRise < n) @(negedge clk);
  endtask

  task automatic doReset(input logic [1:0] m, input logic [2:0] r);
    @(negedge clk);
    enable = 1'b0; mode = m; rateSel = r; rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Compare captured bits [base+from .. base+to] against stream index from..to
  task automatic checkBits(input int base, input int from, input int to, input string req);
    int bad = 0; int firstBad = -1;
    for (int i = from; i <= to; i++)
      if (bitBuf[(base + i) % 4096] != expSeq[i]) begin
        bad++;
        if (firstBad < 0) firstBad = i;
      end
    chk(bad == 0, req, firstBad, -1);
  endtask

  task automatic checkIv(input int base, input int i, input int exp, input string req);
    chk(ivBuf[(base + i) % 4096] == exp, req, ivBuf[(base + i) % 4096], exp);
  endtask

  task automatic testReset;
    @(negedge clk); rstN = 1'b0; enable = 1'b0;
    repeat (2) @(negedge clk);
    chk(!serClk && !serData && !busy, "R10 in reset", {serClk, serData, busy}, 0);
    rstN = 1'b1;
    begin
      int b = nRise;
      repeat (50) @(negedge clk);
      chk(!serClk && !serData && !busy && nRise == b, "R10 idle after reset",
          {serClk, serData, busy}, 0);
    end
  endtask

  task automatic testContinuous;
    int base; int bad = 0;
    doReset(2'b00, 3'd0);
    base = nRise; enable = 1'b1;
    waitRises(base + 80);
    checkBits(base, 0, 79, "R1 R2 stream matches generator");
    for (int i = 1; i < 80; i++) if (ivBuf[(base + i) % 4096] != 8) bad++;
    chk(bad == 0, "R8 R3 no gap, period 8", bad, 0);
  endtask

  task automatic testRate(input logic [2:0] r, input int div, input int n);
    int base; int bad = 0;
    doReset(2'b00, r);
    base = nRise; enable = 1'b1;
    waitRises(base + n);
    for (int i = 1; i < n; i++) if (ivBuf[(base + i) % 4096] != div) bad++;
    chk(bad == 0, "R3 period for rate code", r, div);
    checkBits(base, 0, n - 1, "R1 stream at slow rate");
  endtask

  task automatic testRateChange;
    int base;
    doReset(2'b00, 3'd0);
    base = nRise; enable = 1'b1;
    waitRises(base + 4);
    rateSel = 3'd1;
    waitRises(base + 24);
    checkIv(base, 7, 8, "R4 old rate kept in byte");
    checkIv(base, 8, 12, "R4 boundary interval");
    checkIv(base, 9, 16, "R4 new rate after boundary");
    checkIv(base, 23, 16, "R4 new rate steady");
    checkBits(base, 0, 23, "R1 stream across rate change");
  endtask

  task automatic testShortBurst;
    int base; int g1; int g2;
    doReset(2'b01, 3'd0);
    base = nRise; enable = 1'b1;
    waitRises(base + 64);
    repeat (20) @(negedge clk);
    chk(!busy && !serClk && !serData, "R5 R6 quiet in gap", {busy, serClk, serData}, 0);
    waitRises(base + 130);
    g1 = 16 + int'(stateAt[8][5:0]);
    g2 = 16 + int'(stateAt[16][5:0]);
    checkIv(base, 63, 8, "R5 burst body period");
    checkIv(base, 64, (g1 + 1) * 8, "R5 first gap length");
    checkIv(base, 65, 8, "R5 period after gap");
    checkIv(base, 128, (g2 + 1) * 8, "R5 second gap length");
    checkBits(base, 0, 129, "R1 stream across gaps");
  endtask

  task automatic testLongBurst;
    int base; int g;
    doReset(2'b10, 3'd0);
    base = nRise; enable = 1'b1;
    waitRises(base + 60);
    g = 40 + int'(stateAt[6][3:0]);
    checkIv(base, 47, 8, "R7 long burst body");
    checkIv(base, 48, (g + 1) * 8, "R7 long gap length");
    checkIv(base, 49, 8, "R7 period after long gap");
    checkBits(base, 0, 59, "R7 stream in long mode");
  endtask

  task automatic testStopResume;
    int base;
    doReset(2'b00, 3'd0);
    base = nRise; enable = 1'b1;
    waitRises(base + 21);
    enable = 1'b0;
    repeat (300) @(negedge clk);
    chk(nRise - base == 24, "R9 stop at byte boundary", nRise - base, 24);
    chk(!busy && !serClk && !serData, "R9 idle after stop", {busy, serClk, serData}, 0);
    enable = 1'b1;
    waitRises(base + 40);
    checkBits(base, 24, 39, "R9 resume continues sequence");
  endtask

  initial begin
    logic [30:0] s = 31'd1;
    for (int k = 0; k < 1024; k++) begin
      if (k % 8 == 0 && k / 8 < 128) stateAt[k / 8] = s;
      expSeq[k] = s[30];
      s = {s[29:0], s[30] ^ s[27]};
    end
    testReset();
    testContinuous();
    testRate(3'd2, 32, 24);
    testRate(3'd7, 128, 16);
    testRateChange();
    testShortBurst();
    testLongBurst();
    testStopResume();
    chk(stabFails == 0, "R6 data stable while clock high", stabFails, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule